// File: doc/BRIEF.md
# SPI Command Front End

This block is the slave side of a byte-oriented command link. An external SPI master drives a clock that idles high, a data line and an active-low chip select. The block samples these lines with its own system clock, assembles bytes, and decodes a small command protocol. The commands write one configuration register, read one register back, pick the shift order for later bytes, or fetch a two-byte revision code. Read-type commands always put one ignored byte between the request and the data that comes back.

Bytes that open a bus-transaction command are not run here. The block raises a start strobe carrying the opcode and passes on every later byte of the frame. When chip select is released it raises an end strobe. An external transaction engine consumes these strobes and reports back its busy flag, its status byte and its received-byte count. While chip select is active, a hold output tells that engine to pause its bus activity. The configuration registers are presented as one flat image bus, so the port and bus logic next to this block can decode them.

Top module: `spicmd_frontend`

## Requirements
- R1: After reset the shift order is MSB first. The register image reads all zero except register 0x02, which reads 0xA0. No forwarding strobe is active.
- R2: The frame 0x20, address, value writes the value into the register at that address, for writable addresses 0x00 to 0x09. Only the first value byte of a frame is written, and any later bytes in the same frame change nothing.
- R3: The frame 0x21, address, ignored byte shifts the register value out on MISO during the fourth byte. Address 0x04 returns the engine status input, address 0x06 returns the engine count input, and addresses 0x0A and above return 0x00.
- R4: Writes to address 0x04, to address 0x06 and to addresses 0x0A and above leave the register image unchanged. In the image, slots 0x04 and 0x06 always read 0x00.
- R5: The frame 0x18, 0x81 selects MSB first and the frame 0x18, 0x42 selects LSB first. Both receive and transmit follow the selected order from the next frame on. Any other value after 0x18 leaves the order unchanged.
- R6: The frame 0x40, ignored byte returns the revision bytes 0x01 and then 0x44 in the third and fourth byte slots.
- R7: The opcodes 0x00, 0x01, 0x02, 0x06, 0x08 and 0x09 received as the first byte, with the engine idle, give a start strobe carrying the opcode, then one byte strobe for each later byte, then one end strobe when chip select is released. If the engine is busy when the opcode arrives, the whole frame produces no strobe.
- R8: The hold output is high exactly while the synchronized chip select is active. Register commands are still carried out while the engine is busy.
- R9: Releasing chip select in the middle of a command discards it, so the next frame starts decoding with a fresh opcode. A first byte that is not a known opcode makes the rest of its frame do nothing.
- R10: The MISO enable follows chip select with a delay of two system clocks, which is within the 4-clock limit. MISO reads low when it is not enabled, and during all filler byte slots.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the SPI lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | SPI clock, idles high |
| spi_mosi | input | 1 | Serial data from the master |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_miso | output | 1 | Serial data to the master |
| spi_miso_oe | output | 1 | Output enable for the MISO driver |
| eng_busy | input | 1 | Transaction engine is busy |
| eng_status | input | 8 | Engine status byte, read at address 0x04 |
| eng_rxcount | input | 8 | Engine received-byte count, read at address 0x06 |
| eng_hold | output | 1 | Asks the engine to pause bus activity |
| fwd_start | output | 1 | One-cycle strobe: a transaction command has opened |
| fwd_byte_valid | output | 1 | One-cycle strobe: a command byte is on fwd_data |
| fwd_end | output | 1 | One-cycle strobe: the forwarded command is complete |
| fwd_data | output | 8 | Opcode on fwd_start, parameter byte on fwd_byte_valid |
| reg_image | output | 80 | Flat image of the registers, address n in bits 8n+7:8n |

## Verification
The hardest state to reach from the ports is a change of shift order, because it only shows once the following frames are sent in the new order. The stimulus switches to LSB first and then writes a register and reads it back in that order. An ignored configuration value is shown by a later write and read that still decode correctly in MSB order. An aborted command is followed by a frame made of a single value byte, and that byte would land in a register if the parser had not gone back to idle. Forwarding is run once with the engine idle and once with it busy, and a register write is made during the busy phase.

// File: rtl/spicmd_pkg.sv
package spicmd_pkg;
  typedef logic [7:0] byte_t;

  localparam byte_t OP_REG_WR = 8'h20;
  localparam byte_t OP_REG_RD = 8'h21;
  localparam byte_t OP_ORDER  = 8'h18;
  localparam byte_t OP_REV    = 8'h40;
  localparam byte_t ORDER_MSB = 8'h81;
  localparam byte_t ORDER_LSB = 8'h42;

  localparam int CLK_IDX   = 2;
  localparam int STAT_IDX  = 4;
  localparam int RXCNT_IDX = 6;

  typedef enum logic [3:0] {
    PS_IDLE, PS_WR_ADDR, PS_WR_DATA, PS_RD_ADDR, PS_RD_PAD,
    PS_CFG, PS_REV_PAD, PS_REV_LO, PS_FWD, PS_DRAIN
  } pstate_t;

  function automatic logic is_engine_op(byte_t op);
    case (op)
      8'h00, 8'h01, 8'h02, 8'h06, 8'h08, 8'h09: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic byte_t reg_reset_value(int idx);
    return (idx == CLK_IDX) ? 8'hA0 : 8'h00;
  endfunction
endpackage

// File: rtl/spicmd_sync.sv
module spicmd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_i,
  input  logic mosi_i,
  input  logic cs_n_i,
  output logic sck_rise,
  output logic sck_fall,
  output logic mosi_s,
  output logic cs_idle
);
  // lane order: [2] chip select, [1] clock, [0] data
  localparam logic [2:0] IDLE_LANES = 3'b110;

  logic [STAGES-1:0][2:0] stage_q;
  logic                   sck_last_q;
  logic [2:0]             lanes_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= IDLE_LANES;
      sck_last_q <= 1'b1;
    end else begin
      stage_q[0] <= {cs_n_i, sck_i, mosi_i};
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
      sck_last_q <= lanes_s[1];
    end
  end

  assign lanes_s  = stage_q[STAGES-1];
  assign cs_idle  = lanes_s[2];
  assign mosi_s   = lanes_s[0];
  assign sck_rise = lanes_s[1] & ~sck_last_q;
  assign sck_fall = ~lanes_s[1] & sck_last_q;
endmodule

// File: rtl/spicmd_shifter.sv
module spicmd_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cs_idle,
  input  logic         sck_rise,
  input  logic         sck_fall,
  input  logic         mosi_s,
  input  logic         msb_first,
  input  logic [W-1:0] tx_byte,
  output logic         byte_valid,
  output logic [W-1:0] rx_byte,
  output logic         miso_bit
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [CW-1:0] cnt_q, cnt_d, out_idx;
  logic [W-1:0]  rx_q, rx_d;
  logic          miso_q, miso_d;

  assign out_idx = msb_first ? (LAST - cnt_q) : cnt_q;

  always_comb begin
    cnt_d  = cnt_q;
    rx_d   = rx_q;
    miso_d = miso_q;
    if (cs_idle) begin
      cnt_d  = '0;
      miso_d = 1'b0;               // first slot of a frame is filler
    end else begin
      if (sck_rise) begin
        rx_d  = msb_first ? {rx_q[W-2:0], mosi_s} : {mosi_s, rx_q[W-1:1]};
        cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      end
      if (sck_fall) miso_d = tx_byte[out_idx];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      rx_q   <= '0;
      miso_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      rx_q   <= rx_d;
      miso_q <= miso_d;
    end
  end

  assign byte_valid = ~cs_idle & sck_rise & (cnt_q == LAST);
  assign rx_byte    = rx_d;
  assign miso_bit   = miso_q;

  assert_count_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cs_idle |=> (cnt_q == '0));
endmodule

// File: rtl/spicmd_regfile.sv
module spicmd_regfile
  import spicmd_pkg::*;
#(
  parameter int NUM_REGS = 10
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  byte_t                 addr,
  input  byte_t                 wr_data,
  input  byte_t                 eng_status,
  input  byte_t                 eng_rxcount,
  output byte_t                 rd_data,
  output logic [NUM_REGS*8-1:0] image
);
  localparam byte_t ADDR_LIMIT = 8'(NUM_REGS);

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    if (g == STAT_IDX || g == RXCNT_IDX) begin : g_ro
      assign image[g*8 +: 8] = '0;
    end else begin : g_rw
      byte_t q;
      logic  hit;
      assign hit = wr_en && (addr == 8'(g));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   q <= reg_reset_value(g);
        else if (hit) q <= wr_data;
      end
      assign image[g*8 +: 8] = q;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (addr == 8'(i)) rd_data = image[i*8 +: 8];
    if (addr == 8'(STAT_IDX))  rd_data = eng_status;
    if (addr == 8'(RXCNT_IDX)) rd_data = eng_rxcount;
  end

  assert_image_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(image));

  assert_readonly_write_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (addr == 8'(STAT_IDX) || addr == 8'(RXCNT_IDX) || addr >= ADDR_LIMIT))
      |=> $stable(image));
endmodule

// File: rtl/spicmd_parser.sv
module spicmd_parser
  import spicmd_pkg::*;
#(
  parameter byte_t REV_HI = 8'h01,
  parameter byte_t REV_LO = 8'h44
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  cs_idle,
  input  logic  byte_valid,
  input  byte_t rx_byte,
  input  logic  eng_busy,
  input  byte_t rd_data,
  output logic  msb_first,
  output byte_t tx_byte,
  output byte_t reg_addr,
  output logic  wr_en,
  output byte_t wr_data,
  output logic  fwd_start,
  output logic  fwd_byte_valid,
  output logic  fwd_end,
  output byte_t fwd_data
);
  pstate_t state_q, state_d;
  byte_t   addr_q, addr_d, tx_q, tx_d;
  logic    msb_q, msb_d;

  always_comb begin
    state_d        = state_q;
    addr_d         = addr_q;
    tx_d           = tx_q;
    msb_d          = msb_q;
    wr_en          = 1'b0;
    fwd_start      = 1'b0;
    fwd_byte_valid = 1'b0;
    fwd_end        = 1'b0;
    if (cs_idle) begin
      state_d = PS_IDLE;
      tx_d    = '0;
      fwd_end = (state_q == PS_FWD);
    end else if (byte_valid) begin
      tx_d = '0;
      unique case (state_q)
        PS_IDLE: begin
          if (rx_byte == OP_REG_WR)      state_d = PS_WR_ADDR;
          else if (rx_byte == OP_REG_RD) state_d = PS_RD_ADDR;
          else if (rx_byte == OP_ORDER)  state_d = PS_CFG;
          else if (rx_byte == OP_REV)    state_d = PS_REV_PAD;
          else if (is_engine_op(rx_byte) && !eng_busy) begin
            fwd_start = 1'b1;
            state_d   = PS_FWD;
          end else                       state_d = PS_DRAIN;
        end
        PS_WR_ADDR: begin addr_d = rx_byte; state_d = PS_WR_DATA; end
        PS_WR_DATA: begin wr_en = 1'b1;     state_d = PS_DRAIN;   end
        PS_RD_ADDR: begin addr_d = rx_byte; state_d = PS_RD_PAD;  end
        PS_RD_PAD:  begin tx_d = rd_data;   state_d = PS_DRAIN;   end
        PS_CFG: begin
          if (rx_byte == ORDER_MSB)      msb_d = 1'b1;
          else if (rx_byte == ORDER_LSB) msb_d = 1'b0;
          state_d = PS_DRAIN;
        end
        PS_REV_PAD: begin tx_d = REV_HI; state_d = PS_REV_LO; end
        PS_REV_LO:  begin tx_d = REV_LO; state_d = PS_DRAIN;  end
        PS_FWD:     fwd_byte_valid = 1'b1;
        PS_DRAIN:   state_d = PS_DRAIN;
        default:    state_d = PS_DRAIN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PS_IDLE;
      addr_q  <= '0;
      tx_q    <= '0;
      msb_q   <= 1'b1;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
      tx_q    <= tx_d;
      msb_q   <= msb_d;
    end
  end

  assign msb_first = msb_q;
  assign tx_byte   = tx_q;
  assign reg_addr  = addr_q;
  assign wr_data   = rx_byte;
  assign fwd_data  = rx_byte;

  assert_order_changes_on_byte_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_valid |=> $stable(msb_q));

  assert_fwd_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fwd_start, fwd_byte_valid, fwd_end}));

  assert_busy_blocks_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_start |-> !eng_busy);

  assert_write_while_selected_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !cs_idle);

  assert_abort_to_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cs_idle |=> (state_q == PS_IDLE));
endmodule

// File: rtl/spicmd_frontend.sv
module spicmd_frontend
  import spicmd_pkg::*;
#(
  parameter int    NUM_REGS    = 10,
  parameter int    SYNC_STAGES = 2,
  parameter byte_t REV_HI      = 8'h01,
  parameter byte_t REV_LO      = 8'h44
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  spi_sck,
  input  logic                  spi_mosi,
  input  logic                  spi_cs_n,
  output logic                  spi_miso,
  output logic                  spi_miso_oe,
  input  logic                  eng_busy,
  input  logic [7:0]            eng_status,
  input  logic [7:0]            eng_rxcount,
  output logic                  eng_hold,
  output logic                  fwd_start,
  output logic                  fwd_byte_valid,
  output logic                  fwd_end,
  output logic [7:0]            fwd_data,
  output logic [NUM_REGS*8-1:0] reg_image
);
  logic [1:0] rst_pipe_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_core_n = rst_pipe_q[1];

  logic  sck_rise, sck_fall, mosi_s, cs_idle;
  logic  byte_valid, msb_first, miso_bit, wr_en;
  byte_t rx_byte, tx_byte, reg_addr, wr_data, rd_data;

  spicmd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_core_n),
    .sck_i(spi_sck), .mosi_i(spi_mosi), .cs_n_i(spi_cs_n),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .mosi_s(mosi_s), .cs_idle(cs_idle)
  );

  spicmd_shifter #(.W(8)) u_shift (
    .clk(clk), .rst_n(rst_core_n), .cs_idle(cs_idle),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .mosi_s(mosi_s),
    .msb_first(msb_first), .tx_byte(tx_byte),
    .byte_valid(byte_valid), .rx_byte(rx_byte), .miso_bit(miso_bit)
  );

  spicmd_parser #(.REV_HI(REV_HI), .REV_LO(REV_LO)) u_parse (
    .clk(clk), .rst_n(rst_core_n), .cs_idle(cs_idle),
    .byte_valid(byte_valid), .rx_byte(rx_byte), .eng_busy(eng_busy),
    .rd_data(rd_data), .msb_first(msb_first), .tx_byte(tx_byte),
    .reg_addr(reg_addr), .wr_en(wr_en), .wr_data(wr_data),
    .fwd_start(fwd_start), .fwd_byte_valid(fwd_byte_valid),
    .fwd_end(fwd_end), .fwd_data(fwd_data)
  );

  spicmd_regfile #(.NUM_REGS(NUM_REGS)) u_regs (
    .clk(clk), .rst_n(rst_core_n), .wr_en(wr_en), .addr(reg_addr),
    .wr_data(wr_data), .eng_status(eng_status), .eng_rxcount(eng_rxcount),
    .rd_data(rd_data), .image(reg_image)
  );

  assign spi_miso_oe = ~cs_idle;
  assign spi_miso    = miso_bit & ~cs_idle;
  assign eng_hold    = ~cs_idle;
endmodule

// File: tb/spicmd_frontend_test.sv
module spicmd_frontend_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic spi_sck = 1'b1, spi_mosi = 1'b0, spi_cs_n = 1'b1;
  logic spi_miso, spi_miso_oe, eng_hold;
  logic eng_busy = 1'b0;
  logic [7:0] eng_status = 8'hF3, eng_rxcount = 8'h17;
  logic fwd_start, fwd_byte_valid, fwd_end;
  logic [7:0] fwd_data;
  logic [79:0] reg_image;

  always #4 clk = ~clk;

  spicmd_frontend uut (
    .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
    .spi_cs_n(spi_cs_n), .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
    .eng_busy(eng_busy), .eng_status(eng_status), .eng_rxcount(eng_rxcount),
    .eng_hold(eng_hold), .fwd_start(fwd_start), .fwd_byte_valid(fwd_byte_valid),
    .fwd_end(fwd_end), .fwd_data(fwd_data), .reg_image(reg_image)
  );

  int n_checks = 0, n_fail = 0;
  bit finished = 0, checking = 0, msb_mode = 1;
  logic cs_prev = 1'b1;
  logic [7:0] exp_reg [10];
  logic [7:0] txb [16];
  logic [7:0] rxb [16];
  int n_start = 0, n_end = 0;
  logic [7:0] start_op = 8'h00;
  logic [7:0] fwd_q [$];

  task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  // per-clock reference: synchronized select lags the pin by two edges
  always @(posedge clk) begin
    #2;
    if (checking) begin
      check8("R8 hold", {7'b0, eng_hold}, {7'b0, ~cs_prev});
      check8("R10 miso_oe", {7'b0, spi_miso_oe}, {7'b0, ~cs_prev});
      if (!spi_miso_oe) check8("R10 miso idle", {7'b0, spi_miso}, 8'h00);
    end
    cs_prev = spi_cs_n;
  end

  always @(posedge clk) begin
    #1;
    if (fwd_start) begin n_start++; start_op = fwd_data; end
    if (fwd_byte_valid) fwd_q.push_back(fwd_data);
    if (fwd_end) n_end++;
  end

  task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
    rx = 8'h00;
    for (int i = 0; i < 8; i++) begin
      int idx;
      idx = msb_mode ? 7 - i : i;
      @(negedge clk);
      spi_sck = 1'b0;
      spi_mosi = tx[idx];
      repeat (6) @(negedge clk);
      rx[idx] = spi_miso;
      spi_sck = 1'b1;
      repeat (5) @(negedge clk);
    end
  endtask

  task automatic spi_frame(input int n);
    logic [7:0] r;
    @(negedge clk) spi_cs_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int k = 0; k < n; k++) begin
      spi_byte(txb[k], r);
      rxb[k] = r;
    end
    repeat (4) @(negedge clk);
    spi_cs_n = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  task automatic send2(input logic [7:0] a, input logic [7:0] b);
    txb[0] = a; txb[1] = b; spi_frame(2);
  endtask

  task automatic send3(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c);
    txb[0] = a; txb[1] = b; txb[2] = c; spi_frame(3);
  endtask

  task automatic model_write(input logic [7:0] a, input logic [7:0] d);
    if (a < 8'd10 && a != 8'h04 && a != 8'h06) exp_reg[a] = d;
  endtask

  task automatic check_image(input string req);
    for (int i = 0; i < 10; i++) check8(req, reg_image[i*8 +: 8], exp_reg[i]);
  endtask

  task automatic read_reg(input string req, input logic [7:0] a, input logic [7:0] exp);
    txb[0] = 8'h21; txb[1] = a; txb[2] = 8'hC3; txb[3] = 8'h00;
    spi_frame(4);
    check8(req, rxb[3], exp);
    check8("R10 filler", rxb[2], 8'h00);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 10; i++) exp_reg[i] = (i == 2) ? 8'hA0 : 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    checking = 1;

    // R1 reset state
    check_image("R1 reset image");
    check8("R1 no strobes", {5'b0, fwd_start, fwd_byte_valid, fwd_end}, 8'h00);

    // R2 write, then extra bytes in the same frame
    send3(8'h20, 8'h00, 8'h5A); model_write(8'h00, 8'h5A);
    check_image("R2 write");
    txb[0] = 8'h20; txb[1] = 8'h05; txb[2] = 8'h33; txb[3] = 8'h77; txb[4] = 8'h88;
    spi_frame(5); model_write(8'h05, 8'h33);
    check_image("R2 one per command");

    // R3 reads
    read_reg("R3 read rw", 8'h05, 8'h33);
    read_reg("R3 read clk", 8'h02, 8'hA0);
    read_reg("R3 read status", 8'h04, 8'hF3);
    read_reg("R3 read count", 8'h06, 8'h17);
    read_reg("R3 read beyond", 8'h0C, 8'h00);

    // R4 read-only and out-of-range writes
    send3(8'h20, 8'h04, 8'h99);
    send3(8'h20, 8'h06, 8'h98);
    send3(8'h20, 8'h0B, 8'h97);
    check_image("R4 ignored writes");
    read_reg("R4 status kept", 8'h04, 8'hF3);

    // R6 revision
    txb[0] = 8'h40; txb[1] = 8'h00; txb[2] = 8'h00; txb[3] = 8'h00;
    spi_frame(4);
    check8("R6 rev hi", rxb[2], 8'h01);
    check8("R6 rev lo", rxb[3], 8'h44);
    check8("R10 filler rev", rxb[1], 8'h00);

    // R5 bit order
    send2(8'h18, 8'h55);
    send3(8'h20, 8'h01, 8'h96); model_write(8'h01, 8'h96);
    check_image("R5 bad config ignored");
    read_reg("R5 msb still", 8'h01, 8'h96);
    send2(8'h18, 8'h42); msb_mode = 0;
    send3(8'h20, 8'h07, 8'hC1); model_write(8'h07, 8'hC1);
    check_image("R5 lsb write");
    read_reg("R5 lsb read", 8'h07, 8'hC1);
    txb[0] = 8'h40; txb[1] = 8'h00; txb[2] = 8'h00; txb[3] = 8'h00;
    spi_frame(4);
    check8("R5 lsb rev hi", rxb[2], 8'h01);
    check8("R5 lsb rev lo", rxb[3], 8'h44);
    send2(8'h18, 8'h81); msb_mode = 1;
    send3(8'h20, 8'h08, 8'h3E); model_write(8'h08, 8'h3E);
    check_image("R5 back to msb");

    // R7 forwarding with idle engine
    eng_busy = 1'b0;
    send3(8'h01, 8'h03, 8'hA1);
    check8("R7 start count", 8'(n_start), 8'd1);
    check8("R7 opcode", start_op, 8'h01);
    check8("R7 byte count", 8'(fwd_q.size()), 8'd2);
    if (fwd_q.size() == 2) begin
      check8("R7 byte0", fwd_q[0], 8'h03);
      check8("R7 byte1", fwd_q[1], 8'hA1);
    end
    check8("R7 end count", 8'(n_end), 8'd1);
    fwd_q.delete();

    // R7 busy engine ignores, R8 register path still works
    eng_busy = 1'b1;
    txb[0] = 8'h00; txb[1] = 8'h01; txb[2] = 8'h50; txb[3] = 8'h22;
    spi_frame(4);
    check8("R7 busy no start", 8'(n_start), 8'd1);
    check8("R7 busy no bytes", 8'(fwd_q.size()), 8'd0);
    check8("R7 busy no end", 8'(n_end), 8'd1);
    send3(8'h20, 8'h03, 8'h3C); model_write(8'h03, 8'h3C);
    check_image("R8 write while busy");
    eng_busy = 1'b0;

    // R9 abort mid-command and unknown opcode
    send2(8'h20, 8'h09);
    txb[0] = 8'h55; spi_frame(1);
    check_image("R9 abort");
    txb[0] = 8'h7E; txb[1] = 8'h20; txb[2] = 8'h01; txb[3] = 8'h44;
    spi_frame(4);
    check_image("R9 unknown opcode");
    check8("R9 unknown no start", 8'(n_start), 8'd1);

    checking = 0;
    finish_run();
  end
endmodule